// File: doc/BRIEF.md
# Masked Event Trigger and Pause Qualifier

This block watches a 16-bit external event bus on behalf of a vector sequencer. It raises a trigger request and a pause request for that sequencer. Three compare slots each hold a pattern and a don't-care mask. Two slots, A and B, serve the trigger. The third slot serves the conditional pause. A mask bit of one removes that bus bit from the comparison.

The two trigger slots work in one of two ways. In concurrent mode, a match on either slot fires. In ordered mode, slot A must match first, which arms a flag. A later match on slot B then fires and clears the flag. The trigger is also fed by four direct sources: a software bit, an external trigger pin, a star-style trigger line and a programmed trigger line. These are ORed with the event result, and the trigger output pulses for one cycle on each rising edge of the combined condition. The pause output is a level. It is the OR of a software bit, an external pause pin, a programmed pause line and, when enabled, the pause-slot match.

The live bus passes through a two-flop synchroniser. A control bit can swap the live bus for an emulation register, so that test programs can exercise the event logic with no external hardware. All settings are written through a simple synchronous write port.

Top module: `evq_top`

## Requirements
- R1: After synchronous reset, trig_out and pause_out are low and every register holds zero. With the control register at zero, no bus value produces a trigger or a pause.
- R2: A slot matches when every bus bit whose mask bit is 0 equals the slot's pattern bit. Bits whose mask bit is 1 are ignored.
- R3: With ctl bit 0 (ordered) clear and ctl bit 3 (trigger-event enable) set, a match on slot A or on slot B fires the trigger.
- R4: With ctl bit 0 set, a slot-B match fires only if a slot-A match was seen in an earlier cycle. Firing clears the armed state. Clearing ctl bit 0 or bit 3 also clears it.
- R5: trig_out is high for exactly one cycle per rising edge of the combined trigger condition. A held condition gives a single pulse.
- R6: sw_trig, ext_trig_pin, star_trig and line_trig each fire the trigger on their own, in any combination, one cycle after they rise.
- R7: pause_out equals the OR of sw_pause, ext_pause_pin and line_pause (plus the event pause), delayed by one cycle, and it stays high while any of them is held.
- R8: With ctl bit 2 set, a match on the pause slot holds pause_out high. With ctl bit 2 clear, the pause slot has no effect.
- R9: With ctl bit 1 set, the slots compare against the emulation register, and the live bus has no effect.
- R10: With ctl bit 1 clear, a change on ext_evt reaches trig_out at the third rising clock edge after it is applied, because it passes two synchroniser flops and the output register.
- R11: Write addresses: 0 pattern A, 1 mask A, 2 pattern B, 3 mask B, 4 pause pattern, 5 pause mask, 6 emulation value, 7 control. A write takes effect at the clock edge on which wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_evt | input | 16 | Asynchronous external event bus |
| sw_trig | input | 1 | Software trigger request |
| ext_trig_pin | input | 1 | External trigger pin |
| star_trig | input | 1 | Star-style trigger line |
| line_trig | input | 1 | Programmed trigger line |
| sw_pause | input | 1 | Software pause request |
| ext_pause_pin | input | 1 | External pause pin |
| line_pause | input | 1 | Programmed pause line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| trig_out | output | 1 | One-cycle trigger pulse |
| pause_out | output | 1 | Pause request level |

## Verification
The hardest case to reach is ordered mode in which slot B matches in the same cycle that slot A first arms the flag. It must not fire in that cycle, but it must fire one cycle later. The stimulus sets mask B to all ones so that B matches every value, then writes the emulation register with pattern A and samples the two following cycles. The emulation register also drives a long pseudo-random sweep of bus values and masks, and the bench compares each result against an arithmetic model of the match rule and the edge detector.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NPAIR  = 3;
  localparam int unsigned PAIR_A = 0;
  localparam int unsigned PAIR_B = 1;
  localparam int unsigned PAIR_P = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_A_PAT = 3'd0,
    REG_A_MSK = 3'd1,
    REG_B_PAT = 3'd2,
    REG_B_MSK = 3'd3,
    REG_P_PAT = 3'd4,
    REG_P_MSK = 3'd5,
    REG_EMU   = 3'd6,
    REG_CTL   = 3'd7
  } reg_addr_e;

  // bit 3 trigger-event enable, bit 2 pause-event enable,
  // bit 1 emulation select, bit 0 ordered mode
  typedef struct packed {
    logic trig_evt_en;
    logic pause_evt_en;
    logic emu_sel;
    logic ordered;
  } ctl_t;
endpackage

// File: rtl/evq_sync.sv
module evq_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evq_regs.sv
module evq_regs
  import evq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [W-1:0]               wr_data,
  output logic [NPAIR-1:0][W-1:0]    pat,
  output logic [NPAIR-1:0][W-1:0]    msk,
  output logic [W-1:0]               emu_val,
  output ctl_t                       ctl
);
  localparam logic [ADDR_W-1:0] EMU_ADDR = ADDR_W'(2 * NPAIR);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(2 * NPAIR + 1);

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    localparam logic [ADDR_W-1:0] PAT_ADDR = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(2 * k + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        pat[k] <= '0;
        msk[k] <= '0;
      end else if (wr_en) begin
        if (wr_addr == PAT_ADDR) pat[k] <= wr_data;
        if (wr_addr == MSK_ADDR) msk[k] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      emu_val <= '0;
      ctl     <= '0;
    end else if (wr_en) begin
      if (wr_addr == EMU_ADDR) emu_val <= wr_data;
      if (wr_addr == CTL_ADDR) ctl     <= ctl_t'(wr_data[$bits(ctl_t)-1:0]);
    end
  end
endmodule

// File: rtl/evq_match.sv
module evq_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] bus,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] msk,
  output logic         hit
);
  logic [W-1:0] diff;
  always_comb begin
    diff = (bus ^ pat) & ~msk;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/evq_seq.sv
module evq_seq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ordered,
  input  logic hit_a,
  input  logic hit_b,
  input  logic direct,
  output logic trig_pulse
);
  logic armed;
  logic cond_d;
  logic evt_fire;
  logic cond;

  always_comb begin
    if (!en)          evt_fire = 1'b0;
    else if (ordered) evt_fire = armed & hit_b;
    else              evt_fire = hit_a | hit_b;
    cond = evt_fire | direct;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      cond_d     <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      cond_d     <= cond;
      trig_pulse <= cond & ~cond_d;
      if (!(en && ordered))   armed <= 1'b0;
      else if (armed && hit_b) armed <= 1'b0;
      else if (hit_a)          armed <= 1'b1;
    end
  end

  // R4: leaving ordered mode or disabling events drops the armed state
  a_r4_disarm_off: assert property (@(posedge clk) disable iff (rst)
    !(en && ordered) |=> !armed);

  // R5: a pulse never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);
endmodule

// File: rtl/evq_top.sv
module evq_top
  import evq_pkg::*;
#(
  parameter int EVT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  ext_evt,
  input  logic              sw_trig,
  input  logic              ext_trig_pin,
  input  logic              star_trig,
  input  logic              line_trig,
  input  logic              sw_pause,
  input  logic              ext_pause_pin,
  input  logic              line_pause,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [EVT_W-1:0]  wr_data,
  output logic              trig_out,
  output logic              pause_out
);
  logic [EVT_W-1:0]            evt_sync;
  logic [EVT_W-1:0]            evt_bus;
  logic [NPAIR-1:0][EVT_W-1:0] pat;
  logic [NPAIR-1:0][EVT_W-1:0] msk;
  logic [EVT_W-1:0]            emu_val;
  ctl_t                        ctl;
  logic [NPAIR-1:0]            hit;
  logic                        trig_direct;
  logic                        pause_cond;
  logic                        pause_q;

  evq_sync #(.W(EVT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_evt),
    .q   (evt_sync)
  );

  evq_regs #(.W(EVT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pat     (pat),
    .msk     (msk),
    .emu_val (emu_val),
    .ctl     (ctl)
  );

  assign evt_bus = ctl.emu_sel ? emu_val : evt_sync;

  for (genvar k = 0; k < NPAIR; k++) begin : g_cmp
    evq_match #(.W(EVT_W)) u_match (
      .bus (evt_bus),
      .pat (pat[k]),
      .msk (msk[k]),
      .hit (hit[k])
    );
  end

  assign trig_direct = sw_trig | ext_trig_pin | star_trig | line_trig;

  evq_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (ctl.trig_evt_en),
    .ordered    (ctl.ordered),
    .hit_a      (hit[PAIR_A]),
    .hit_b      (hit[PAIR_B]),
    .direct     (trig_direct),
    .trig_pulse (trig_out)
  );

  assign pause_cond = sw_pause | ext_pause_pin | line_pause
                    | (ctl.pause_evt_en & hit[PAIR_P]);

  always_ff @(posedge clk) begin
    if (rst) pause_q <= 1'b0;
    else     pause_q <= pause_cond;
  end

  assign pause_out = pause_q;

  // R1: both requests are low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!trig_out && !pause_out));

  // R7: any direct pause input raises the pause level one cycle later
  a_r7_direct_pause: assert property (@(posedge clk) disable iff (rst)
    (sw_pause || ext_pause_pin || line_pause) |=> pause_out);
endmodule

// File: tb/evq_top_test.sv
`timescale 1ns/1ps
module evq_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_evt = '0;
  logic        sw_trig = 0, ext_trig_pin = 0, star_trig = 0, line_trig = 0;
  logic        sw_pause = 0, ext_pause_pin = 0, line_pause = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig_out, pause_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] a_p = 0, a_m = 0, b_p = 0, b_m = 0, emu = 0;
  logic        cprev = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  evq_top uut (
    .clk(clk), .rst(rst), .ext_evt(ext_evt),
    .sw_trig(sw_trig), .ext_trig_pin(ext_trig_pin), .star_trig(star_trig),
    .line_trig(line_trig), .sw_pause(sw_pause), .ext_pause_pin(ext_pause_pin),
    .line_pause(line_pause), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_out(trig_out), .pause_out(pause_out)
  );

  function automatic logic mt(input logic [15:0] bus, pat, msk);
    return ((bus ^ pat) & ~msk) == 16'h0;
  endfunction

  function automatic logic model_cond();
    return mt(emu, a_p, a_m) | mt(emu, b_p, b_m);
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      3'd0: a_p = d;
      3'd1: a_m = d;
      3'd2: b_p = d;
      3'd3: b_m = d;
      3'd6: emu = d;
      default: ;
    endcase
  endtask

  // concurrent mode, emulation selected: write then check edge-detected pulse
  task automatic step(input string req, input logic [2:0] a, input logic [15:0] d);
    logic cnow;
    wr(a, d);
    cnow = model_cond();
    @(negedge clk);
    chk(req, trig_out, cnow & ~cprev);
    cprev = cnow;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    cprev = model_cond();
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], 1'b0} ^ (v[15] ? 16'h100B : 16'h0000);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state; registers zero so slot A (0/0) matches bus 0, but events disabled
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", trig_out, 1'b0);
      chk("R1", pause_out, 1'b0);
    end

    // R11: program the map
    wr(3'd0, 16'h1234);
    wr(3'd2, 16'hABCD);
    wr(3'd4, 16'h00F0);
    wr(3'd5, 16'hFF0F);
    wr(3'd7, 16'h000A);   // trigger events on, emulation on, concurrent
    settle();
    chk("R11", trig_out, 1'b0);
    step("R11", 3'd6, 16'h1234);
    step("R11", 3'd6, 16'h0000);

    // R2: single compared bit sweep on slot A
    for (int i = 0; i < 16; i++) begin
      step("R2", 3'd1, ~(16'h1 << i));
      step("R2", 3'd6, a_p ^ (16'h1 << i));
      step("R2", 3'd6, ~a_p ^ (16'h1 << i));
      step("R2", 3'd6, 16'h0000);
    end
    step("R2", 3'd1, 16'h0000);

    // R3/R5: pseudo-random sweep, either slot fires
    for (int j = 0; j < 96; j++) begin
      lfsr = nxt(lfsr);
      if (j % 8 == 0) begin
        step("R3", 3'd1, lfsr | nxt(lfsr));
        lfsr = nxt(lfsr);
        step("R3", 3'd3, lfsr & nxt(lfsr));
        lfsr = nxt(lfsr);
      end
      case (j % 3)
        0: step("R3", 3'd6, a_p ^ (lfsr & a_m));
        1: step("R3", 3'd6, b_p ^ (lfsr & b_m));
        default: step("R5", 3'd6, lfsr);
      endcase
    end
    step("R5", 3'd6, a_p);
    @(negedge clk);
    chk("R5", trig_out, 1'b0);  // held match, no second pulse
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd6, 16'h0000);
    settle();

    // R4: ordered mode
    wr(3'd7, 16'h000B);
    settle();
    wr(3'd6, b_p);  @(negedge clk); chk("R4", trig_out, 1'b0);  // B without A
    wr(3'd6, a_p);  @(negedge clk); chk("R4", trig_out, 1'b0);  // arms
    wr(3'd6, 16'h0); @(negedge clk); chk("R4", trig_out, 1'b0);
    wr(3'd6, b_p);  @(negedge clk); chk("R4", trig_out, 1'b1);  // fires
    wr(3'd6, 16'h0); @(negedge clk); chk("R4", trig_out, 1'b0);
    wr(3'd6, b_p);  @(negedge clk); chk("R4", trig_out, 1'b0);  // disarmed
    wr(3'd6, 16'h0);
    // same-cycle A and B: B mask all ones
    wr(3'd3, 16'hFFFF);
    settle();
    wr(3'd6, a_p);
    @(negedge clk); chk("R4", trig_out, 1'b0);
    @(negedge clk); chk("R4", trig_out, 1'b1);
    wr(3'd3, 16'h0000);
    wr(3'd6, 16'h0000);
    // R4: arm, then leave ordered mode, return, B must not fire
    wr(3'd6, a_p);
    wr(3'd6, 16'h0);
    wr(3'd7, 16'h000A);
    wr(3'd7, 16'h000B);
    settle();
    wr(3'd6, b_p); @(negedge clk); chk("R4", trig_out, 1'b0);
    wr(3'd6, 16'h0);
    wr(3'd7, 16'h000A);
    settle();

    // R6: all combinations of direct trigger sources
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      {line_trig, star_trig, ext_trig_pin, sw_trig} = 4'(c);
      @(negedge clk); chk("R6", trig_out, c != 0);
      @(negedge clk); chk("R5", trig_out, 1'b0);
      {line_trig, star_trig, ext_trig_pin, sw_trig} = 4'h0;
      repeat (2) @(negedge clk);
    end

    // R7: direct pause sources
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      {line_pause, ext_pause_pin, sw_pause} = 3'(c);
      @(negedge clk); chk("R7", pause_out, c != 0);
      @(negedge clk); chk("R7", pause_out, c != 0);
      {line_pause, ext_pause_pin, sw_pause} = 3'h0;
      @(negedge clk); chk("R7", pause_out, 1'b0);
    end

    // R8: conditional pause on slot P (pattern 0x00F0, mask 0xFF0F)
    wr(3'd6, 16'h12F4); @(negedge clk); chk("R8", pause_out, 1'b0); // disabled
    wr(3'd7, 16'h000E);
    wr(3'd6, 16'h0050); @(negedge clk); chk("R8", pause_out, 1'b0);
    wr(3'd6, 16'h12F4); @(negedge clk); chk("R8", pause_out, 1'b1);
    wr(3'd7, 16'h000A); @(negedge clk); chk("R8", pause_out, 1'b0);
    wr(3'd6, 16'h0000);
    settle();

    // R9: live bus ignored while emulation selected
    @(negedge clk); ext_evt = 16'h1234;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R9", trig_out, 1'b0);
    end
    ext_evt = 16'h0000;
    wr(3'd7, 16'h0008);
    repeat (4) @(negedge clk);

    // R10: latency through the synchroniser
    ext_evt = 16'h1234;
    @(negedge clk); chk("R10", trig_out, 1'b0);
    @(negedge clk); chk("R10", trig_out, 1'b0);
    @(negedge clk); chk("R10", trig_out, 1'b1);
    @(negedge clk); chk("R10", trig_out, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule